// File: doc/BRIEF.md
# DMA Descriptor List Walker

This block follows a linked list of DMA descriptors kept in memory, for one transfer direction. Once started, it reads each descriptor through a single-outstanding memory read port, checks whether the descriptor belongs to the DMA, and hands the consumer up to two buffers (address and byte count) one at a time over a valid/ready handshake. When the consumer reports that the descriptor is finished, the walker writes the descriptor's first word back with the ownership flag cleared, then moves to the next descriptor.

The next descriptor is either the one that follows in memory (the step is a descriptor of 4 or 8 words), the one named by a link pointer that takes the place of the second buffer address, or the list base when the descriptor closes a ring. A descriptor that the DMA does not own halts the walk until software issues a poll pulse. One parameter selects the direction and with it the position of the link and ring flags.

Layout used by the walker (word k sits at descriptor address + 4·k): word 0 holds the flags and is the word written back, word 1 holds the two buffer sizes, word 2 the first buffer address, word 3 the second buffer address or the link pointer. Words 4 to 7 of a long descriptor are never read.

Top module: `dlw_walker`

## Requirements
- R1: A start pulse while idle latches `list_base_i` as the list base and as the current descriptor; each descriptor is then read as exactly four words, at offsets +0, +4, +8, +12 in that order.
- R2: If word 0 (the first word read) has bit 31 clear, no further word of that descriptor is read, no buffer is presented, and `suspended_o` rises and stays high until a `poll_i` pulse; the walker then re-reads the same descriptor from word 0.
- R3: For a descriptor with the link flag clear, buffer one (address = word 2, size = word 1 bits 12:0, `buf_second_o` = 0) is presented before buffer two (address = word 3, size = word 1 bits 28:16, `buf_second_o` = 1).
- R4: With the link flag set (word 0 bit 14 when IS_TX = 0, bit 20 when IS_TX = 1), only buffer one is presented and the next descriptor address is word 3.
- R5: With both the link and ring flags clear, the next descriptor address is the current one plus 16 bytes when `desc_wide_i` = 0, or plus 32 bytes when it is 1.
- R6: With the ring flag set (word 0 bit 15 when IS_TX = 0, bit 21 when IS_TX = 1), the next descriptor address is the latched list base, whatever the link flag says.
- R7: A buffer whose size field is zero is never presented; a descriptor with both sizes zero goes straight to waiting for completion.
- R8: After all buffers are taken, `desc_hold_o` is high until `desc_done_i`; the walker then issues one write to the descriptor's address carrying word 0 with bit 31 cleared and every other bit unchanged, and reads the next descriptor only after `wr_ack_i`. Reads and writes never overlap.
- R9: A presented buffer keeps `buf_valid_o`, `buf_addr_o`, `buf_size_o` and `buf_second_o` unchanged until it is accepted with `buf_ready_i`.
- R10: After reset the walker is idle: no read, no write, no buffer, `desc_hold_o` and `suspended_o` low, and it stays so until a start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin walking from the list base (honoured while idle) |
| list_base_i | input | ADDR_W | Byte address of the first descriptor |
| desc_wide_i | input | 1 | Descriptor step: 0 = 4 words, 1 = 8 words |
| poll_i | input | 1 | Resume pulse after a suspension |
| rd_req_o | output | 1 | Read request, held until `rd_valid_i` |
| rd_addr_o | output | ADDR_W | Byte address of the word being read |
| rd_valid_i | input | 1 | Read data returned this cycle |
| rd_data_i | input | DATA_W | Read data |
| wr_req_o | output | 1 | Write-back request, held until `wr_ack_i` |
| wr_addr_o | output | ADDR_W | Write-back byte address |
| wr_data_o | output | DATA_W | Write-back data (word 0, ownership cleared) |
| wr_ack_i | input | 1 | Write accepted |
| buf_valid_o | output | 1 | A buffer is presented |
| buf_addr_o | output | ADDR_W | Buffer start address |
| buf_size_o | output | SIZE_W | Buffer size in bytes |
| buf_second_o | output | 1 | 0 = first buffer, 1 = second buffer |
| buf_ready_i | input | 1 | Consumer takes the presented buffer |
| desc_hold_o | output | 1 | Walker waits for the consumer to finish the descriptor |
| desc_done_i | input | 1 | Consumer has finished the descriptor |
| suspended_o | output | 1 | Halted on a descriptor the DMA does not own |

## Verification
The bench goes after the next-address choice when flags collide: a descriptor carrying both the link and the ring flag must return to the base, and a walker that let the link win would jump into the list's middle and read the wrong words. Zero-size buffers in either slot, and in both at once, are aimed at a design that would hand the consumer an empty transfer or stall waiting for a handshake that never comes. An unowned descriptor in the middle of the walk catches a design that keeps reading past word 0, presents stale buffers, or resumes at the following descriptor rather than re-reading the suspended one. Random word 0 contents check that the write-back clears only the ownership bit, and random memory and consumer latencies check that presented buffers and read addresses hold still while waiting.

// File: rtl/dlw_pkg.sv
package dlw_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_READ  = 3'd1,
    S_PRES1 = 3'd2,
    S_PRES2 = 3'd3,
    S_HOLD  = 3'd4,
    S_WBACK = 3'd5,
    S_SUSP  = 3'd6
  } walk_st_t;

  // Word 0 flag positions depend on the direction.
  function automatic int link_pos(bit is_tx);
    return is_tx ? 20 : 14;
  endfunction

  function automatic int ring_pos(bit is_tx);
    return is_tx ? 21 : 15;
  endfunction

  // Bytes between two contiguous descriptors.
  function automatic int desc_step(bit wide, int word_bytes);
    return (wide ? 8 : 4) * word_bytes;
  endfunction

  // Byte offset of word k inside a descriptor.
  function automatic int word_off(logic [1:0] k, int word_bytes);
    return int'(k) * word_bytes;
  endfunction

endpackage

// File: rtl/dlw_desc_regs.sv
module dlw_desc_regs #(
  parameter int DATA_W = 32,
  parameter int SIZE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [1:0]        cap_idx,
  input  logic [DATA_W-1:0] cap_data,
  output logic [DATA_W-1:0] flags_w,
  output logic [SIZE_W-1:0] size_a,
  output logic [SIZE_W-1:0] size_b,
  output logic [DATA_W-1:0] addr_a_w,
  output logic [DATA_W-1:0] addr_b_w
);
  localparam int SZB_LSB = DATA_W / 2;

  // word 1 keeps only its two size fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_w  <= '0;
      size_a   <= '0;
      size_b   <= '0;
      addr_a_w <= '0;
      addr_b_w <= '0;
    end else if (cap_en) begin
      case (cap_idx)
        2'd0: flags_w <= cap_data;
        2'd1: begin
          size_a <= cap_data[SIZE_W-1:0];
          size_b <= cap_data[SZB_LSB +: SIZE_W];
        end
        2'd2: addr_a_w <= cap_data;
        default: addr_b_w <= cap_data;
      endcase
    end
  end

  p_cap_only_when_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(flags_w) && $stable(addr_a_w) && $stable(addr_b_w));

endmodule

// File: rtl/dlw_next_addr.sv
module dlw_next_addr import dlw_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] link_addr,
  input  logic              wide,
  input  logic              ring_flag,
  input  logic              link_flag,
  output logic [ADDR_W-1:0] next_addr,
  output logic              took_ring,
  output logic              took_link
);
  logic [ADDR_W-1:0] seq_addr;

  always_comb begin
    seq_addr  = cur_addr + ADDR_W'(desc_step(wide, WORD_BYTES));
    took_ring = ring_flag;
    took_link = link_flag && !ring_flag;
    if (took_ring)      next_addr = base_addr;
    else if (took_link) next_addr = link_addr;
    else                next_addr = seq_addr;
  end

  // ring wins over link (R6)
  always_comb begin
    if (ring_flag) p_ring_over_link_r6: assert (!took_link);
  end

endmodule

// File: rtl/dlw_buf_pick.sv
module dlw_buf_pick #(
  parameter int SIZE_W = 13
) (
  input  logic              link_flag,
  input  logic [SIZE_W-1:0] size_a,
  input  logic [SIZE_W-1:0] size_b,
  output logic              use_a,
  output logic              use_b
);
  always_comb begin
    use_a = (size_a != '0);
    use_b = (size_b != '0) && !link_flag;
  end
endmodule

// File: rtl/dlw_walker.sv
module dlw_walker import dlw_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 13,
  parameter bit IS_TX  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] list_base_i,
  input  logic              desc_wide_i,
  input  logic              poll_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ack_i,
  output logic              buf_valid_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic [SIZE_W-1:0] buf_size_o,
  output logic              buf_second_o,
  input  logic              buf_ready_i,
  output logic              desc_hold_o,
  input  logic              desc_done_i,
  output logic              suspended_o
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int OWN_BIT    = DATA_W - 1;
  localparam int LINK_BIT   = link_pos(IS_TX);
  localparam int RING_BIT   = ring_pos(IS_TX);

  walk_st_t          st;
  logic [1:0]        widx;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] base_q;

  logic [DATA_W-1:0] flags_w, addr_a_w, addr_b_w;
  logic [SIZE_W-1:0] size_a, size_b;
  logic              use_a, use_b;
  logic [ADDR_W-1:0] next_addr;
  logic              took_ring, took_link;

  // named events for the assertions
  logic rd_take, own_miss, buf_take, wb_done;
  assign rd_take  = (st == S_READ) && rd_valid_i;
  assign own_miss = rd_take && (widx == 2'd0) && !rd_data_i[OWN_BIT];
  assign buf_take = buf_valid_o && buf_ready_i;
  assign wb_done  = (st == S_WBACK) && wr_ack_i;

  dlw_desc_regs #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cap_en(rd_take), .cap_idx(widx),
    .cap_data(rd_data_i), .flags_w(flags_w), .size_a(size_a),
    .size_b(size_b), .addr_a_w(addr_a_w), .addr_b_w(addr_b_w)
  );

  dlw_buf_pick #(.SIZE_W(SIZE_W)) u_pick (
    .link_flag(flags_w[LINK_BIT]), .size_a(size_a), .size_b(size_b),
    .use_a(use_a), .use_b(use_b)
  );

  dlw_next_addr #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_next (
    .cur_addr(cur_addr), .base_addr(base_q), .link_addr(ADDR_W'(addr_b_w)),
    .wide(desc_wide_i), .ring_flag(flags_w[RING_BIT]),
    .link_flag(flags_w[LINK_BIT]), .next_addr(next_addr),
    .took_ring(took_ring), .took_link(took_link)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      widx     <= 2'd0;
      cur_addr <= '0;
      base_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          base_q   <= list_base_i;
          cur_addr <= list_base_i;
          widx     <= 2'd0;
          st       <= S_READ;
        end
        S_READ: if (rd_take) begin
          if (own_miss) begin
            widx <= 2'd0;
            st   <= S_SUSP;
          end else if (widx == 2'd3) begin
            widx <= 2'd0;
            st   <= S_PRES1;
          end else begin
            widx <= widx + 2'd1;
          end
        end
        S_SUSP:  if (poll_i) st <= S_READ;
        S_PRES1: if (!use_a || buf_take) st <= S_PRES2;
        S_PRES2: if (!use_b || buf_take) st <= S_HOLD;
        S_HOLD:  if (desc_done_i) st <= S_WBACK;
        S_WBACK: if (wr_ack_i) begin
          cur_addr <= next_addr;
          st       <= S_READ;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_req_o     = (st == S_READ);
    rd_addr_o    = cur_addr + ADDR_W'(word_off(widx, WORD_BYTES));
    wr_req_o     = (st == S_WBACK);
    wr_addr_o    = cur_addr;
    wr_data_o    = flags_w & ~(DATA_W'(1) << OWN_BIT);
    buf_valid_o  = ((st == S_PRES1) && use_a) || ((st == S_PRES2) && use_b);
    buf_second_o = (st == S_PRES2);
    buf_addr_o   = (st == S_PRES2) ? ADDR_W'(addr_b_w) : ADDR_W'(addr_a_w);
    buf_size_o   = (st == S_PRES2) ? size_b : size_a;
    desc_hold_o  = (st == S_HOLD);
    suspended_o  = (st == S_SUSP);
  end

  p_start_at_base_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start_i) |=> rd_req_o && rd_addr_o == $past(list_base_i));

  p_own_suspend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    own_miss |=> suspended_o && !rd_req_o && !buf_valid_o);

  p_suspend_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended_o && !poll_i) |=> suspended_o);

  p_poll_reread_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended_o && poll_i) |=> rd_req_o && rd_addr_o == $past(cur_addr));

  p_link_one_buf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid_o && buf_second_o) |-> !flags_w[LINK_BIT]);

  p_link_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_done && took_link) |=> rd_addr_o == $past(ADDR_W'(addr_b_w)));

  p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_done |=> rd_req_o && rd_addr_o == $past(next_addr));

  p_ring_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_done && took_ring) |=> rd_addr_o == base_q);

  p_no_empty_buf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid_o |-> buf_size_o != '0);

  p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_o && wr_req_o));

  p_hold_until_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_hold_o && !desc_done_i) |=> desc_hold_o);

  p_buf_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid_o && !buf_ready_i) |=> buf_valid_o && $stable(buf_addr_o)
      && $stable(buf_size_o) && $stable(buf_second_o));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !rd_req_o && !wr_req_o && !buf_valid_o && !suspended_o);

endmodule

// File: tb/dlw_walker_bench.sv
module dlw_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, desc_wide_i, poll_i;
  logic [31:0] list_base_i;
  logic        rd_req_o, rd_valid_i, wr_req_o, wr_ack_i;
  logic [31:0] rd_addr_o, rd_data_i, wr_addr_o, wr_data_o, buf_addr_o;
  logic [12:0] buf_size_o;
  logic        buf_valid_o, buf_second_o, buf_ready_i;
  logic        desc_hold_o, desc_done_i, suspended_o;

  int total = 0, fails = 0, lat = 0;
  logic [31:0] mem [256];
  logic [31:0] rlog[$];
  logic [31:0] wlog_a[$];
  logic [31:0] wlog_d[$];

  always #5 clk = ~clk;

  dlw_walker u_dlw_walker (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .list_base_i(list_base_i),
    .desc_wide_i(desc_wide_i), .poll_i(poll_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
    .rd_data_i(rd_data_i), .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i), .buf_valid_o(buf_valid_o),
    .buf_addr_o(buf_addr_o), .buf_size_o(buf_size_o),
    .buf_second_o(buf_second_o), .buf_ready_i(buf_ready_i),
    .desc_hold_o(desc_hold_o), .desc_done_i(desc_done_i),
    .suspended_o(suspended_o)
  );

  function automatic int wi(logic [31:0] a);
    return int'(a[9:2]);
  endfunction

  // receive direction: link flag bit 14, ring flag bit 15, own bit 31
  function automatic logic [31:0] exp_next(logic [31:0] ea, logic [31:0] w0,
                                           logic [31:0] w3, logic wide,
                                           logic [31:0] base);
    if (w0[15]) return base;
    if (w0[14]) return w3;
    return ea + (wide ? 32'd32 : 32'd16);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: random read latency, single-cycle write ack
  initial begin
    rd_valid_i = 1'b0; rd_data_i = '0; wr_ack_i = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        rd_valid_i = 1'b0; wr_ack_i = 1'b0; lat = 0;
      end else begin
        if (rd_valid_i) rd_valid_i = 1'b0;
        else if (rd_req_o) begin
          if (lat == 0) begin
            rd_data_i = mem[wi(rd_addr_o)];
            rd_valid_i = 1'b1;
            rlog.push_back(rd_addr_o);
            lat = $urandom_range(0, 2);
          end else lat--;
        end
        if (wr_ack_i) wr_ack_i = 1'b0;
        else if (wr_req_o) begin
          mem[wi(wr_addr_o)] = wr_data_o;
          wr_ack_i = 1'b1;
          wlog_a.push_back(wr_addr_o);
          wlog_d.push_back(wr_data_o);
        end
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; start_i = 1'b0; poll_i = 1'b0; buf_ready_i = 1'b0;
    desc_done_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rlog.delete(); wlog_a.delete(); wlog_d.delete();
  endtask

  task automatic do_start(input logic [31:0] base);
    list_base_i = base;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic walk_one(inout logic [31:0] ea, input logic [31:0] base);
    logic [31:0] w0, w1, w2, w3;
    logic [31:0] ex_a [2];
    logic [12:0] ex_s [2];
    bit          ex_sec [2];
    int          ex_n, got, guard;
    w0 = mem[wi(ea)];
    if (!w0[31]) begin
      guard = 0;
      while (!suspended_o && guard < 200) begin @(negedge clk); guard++; end
      chk(suspended_o, "R2 suspend raised", 32'(suspended_o), 32'd1);
      chk(rlog.size() == 1 && rlog[0] == ea, "R2 only word 0 read",
          32'(rlog.size()), 32'd1);
      repeat (6) @(negedge clk);
      chk(suspended_o && !rd_req_o && !buf_valid_o, "R2 stays suspended",
          {29'd0, suspended_o, rd_req_o, buf_valid_o}, 32'h4);
      mem[wi(ea)][31] = 1'b1;
      rlog.delete();
      poll_i = 1'b1; @(negedge clk); poll_i = 1'b0;
      w0 = mem[wi(ea)];
    end
    w1 = mem[wi(ea + 4)]; w2 = mem[wi(ea + 8)]; w3 = mem[wi(ea + 12)];
    ex_n = 0;
    ex_a[0] = '0; ex_a[1] = '0; ex_s[0] = '0; ex_s[1] = '0;
    ex_sec[0] = 1'b0; ex_sec[1] = 1'b0;
    if (w1[12:0] != 0) begin
      ex_a[ex_n] = w2; ex_s[ex_n] = w1[12:0]; ex_sec[ex_n] = 1'b0; ex_n++;
    end
    if (!w0[14] && w1[28:16] != 0) begin
      ex_a[ex_n] = w3; ex_s[ex_n] = w1[28:16]; ex_sec[ex_n] = 1'b1; ex_n++;
    end
    got = 0; guard = 0;
    while (!desc_hold_o && guard < 400) begin
      if (buf_valid_o) begin
        logic [31:0] a0;
        a0 = buf_addr_o;
        if (got < ex_n)
          chk(buf_addr_o == ex_a[got] && buf_size_o == ex_s[got]
              && buf_second_o == ex_sec[got], "R3 R4 buffer contents",
              buf_addr_o, ex_a[got]);
        else
          chk(1'b0, "R7 R4 extra buffer", buf_addr_o, 32'd0);
        repeat ($urandom_range(0, 2)) @(negedge clk);
        chk(buf_valid_o && buf_addr_o == a0, "R9 buffer held", buf_addr_o, a0);
        buf_ready_i = 1'b1; @(negedge clk); buf_ready_i = 1'b0;
        got++;
      end else @(negedge clk);
      guard++;
    end
    chk(desc_hold_o, "R8 completion wait reached", 32'(desc_hold_o), 32'd1);
    chk(got == ex_n, "R7 presented buffer count", 32'(got), 32'(ex_n));
    chk(rlog.size() == 4, "R1 four word reads", 32'(rlog.size()), 32'd4);
    for (int k = 0; k < 4 && k < rlog.size(); k++)
      chk(rlog[k] == ea + 32'(4 * k), "R1 word read order", rlog[k],
          ea + 32'(4 * k));
    rlog.delete();
    repeat ($urandom_range(0, 2)) @(negedge clk);
    chk(desc_hold_o && !rd_req_o && !wr_req_o, "R8 holds before done",
        {30'd0, desc_hold_o, wr_req_o}, 32'h2);
    desc_done_i = 1'b1; @(negedge clk); desc_done_i = 1'b0;
    guard = 0;
    while (wlog_a.size() == 0 && guard < 50) begin @(negedge clk); guard++; end
    chk(wlog_a.size() == 1, "R8 one write-back", 32'(wlog_a.size()), 32'd1);
    if (wlog_a.size() > 0)
      chk(wlog_a[0] == ea && wlog_d[0] == (w0 & 32'h7fff_ffff),
          "R8 write-back word", wlog_d[0], w0 & 32'h7fff_ffff);
    wlog_a.delete(); wlog_d.delete();
    mem[wi(ea)][31] = 1'b1;
    ea = exp_next(ea, w0, w3, desc_wide_i, base);
  endtask

  task automatic build_ring(input logic [31:0] base, input int n, input bit wide);
    int stride = wide ? 32 : 16;
    for (int i = 0; i < n; i++) begin
      logic [31:0] a, w0, w1;
      int pick;
      bit lnk;
      a = base + 32'(i * stride);
      lnk = ($urandom_range(0, 2) == 0);
      w0 = ($urandom & 32'h7fff_3fff) | 32'h8000_0000;
      w0[14] = lnk;
      w0[15] = (i == n - 1);
      w1 = '0;
      w1[12:0]  = ($urandom_range(0, 3) == 0) ? 13'd0 : 13'($urandom_range(1, 8191));
      w1[28:16] = ($urandom_range(0, 3) == 0) ? 13'd0 : 13'($urandom_range(1, 8191));
      pick = $urandom_range(0, n - 2);
      if (pick >= i) pick++;
      mem[wi(a)] = w0; mem[wi(a + 4)] = w1; mem[wi(a + 8)] = $urandom;
      mem[wi(a + 12)] = lnk ? base + 32'(pick * stride) : $urandom;
    end
  endtask

  initial begin
    logic [31:0] ea;
    void'($urandom(32'd20240607));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    desc_wide_i = 1'b0; list_base_i = '0;
    do_reset();
    repeat (4) @(negedge clk);
    chk(!rd_req_o && !wr_req_o && !buf_valid_o && !desc_hold_o && !suspended_o,
        "R10 idle after reset",
        {27'd0, rd_req_o, wr_req_o, buf_valid_o, desc_hold_o, suspended_o}, 32'd0);

    // random ring, 4-word step
    desc_wide_i = 1'b0;
    build_ring(32'h100, 8, 1'b0);
    do_start(32'h100);
    ea = 32'h100;
    for (int d = 0; d < 24; d++) walk_one(ea, 32'h100);

    // random ring, 8-word step (R5)
    do_reset();
    desc_wide_i = 1'b1;
    build_ring(32'h200, 7, 1'b1);
    do_start(32'h200);
    ea = 32'h200;
    for (int d = 0; d < 24; d++) walk_one(ea, 32'h200);

    // directed: zero sizes, unowned descriptor, link plus ring
    do_reset();
    desc_wide_i = 1'b0;
    mem[wi(32'h040)] = 32'h8000_0000;            // slot0: first size zero (R7)
    mem[wi(32'h044)] = {3'd0, 13'd5, 3'd0, 13'd0};
    mem[wi(32'h048)] = 32'hAAAA_0000; mem[wi(32'h04C)] = 32'hBBBB_0000;
    mem[wi(32'h050)] = 32'h0000_4123;            // slot1: unowned, linked (R2 R4)
    mem[wi(32'h054)] = {3'd0, 13'd9, 3'd0, 13'd7};
    mem[wi(32'h058)] = 32'hCCCC_0000; mem[wi(32'h05C)] = 32'h0000_0060;
    mem[wi(32'h060)] = 32'h8000_0055;            // slot2: both sizes zero (R7)
    mem[wi(32'h064)] = 32'h0;
    mem[wi(32'h068)] = 32'hDDDD_0000; mem[wi(32'h06C)] = 32'hEEEE_0000;
    mem[wi(32'h070)] = 32'h8000_C000;            // slot3: link and ring (R6)
    mem[wi(32'h074)] = {3'd0, 13'd3, 3'd0, 13'd4};
    mem[wi(32'h078)] = 32'h1234_0000; mem[wi(32'h07C)] = 32'h0000_0060;
    do_start(32'h040);
    ea = 32'h040;
    for (int d = 0; d < 6; d++) begin
      logic [31:0] e_prev;
      e_prev = ea;
      walk_one(ea, 32'h040);
      if (e_prev == 32'h070) chk(ea == 32'h040, "R6 ring returns to base", ea, 32'h040);
      if (e_prev == 32'h050) chk(ea == 32'h060, "R4 link pointer followed", ea, 32'h060);
    end
    // make slot1 unowned again to re-test a suspension after a ring wrap (R2)
    mem[wi(32'h050)][31] = 1'b0;
    ea = 32'h060;
    walk_one(ea, 32'h040);
    walk_one(ea, 32'h040);
    walk_one(ea, 32'h040);
    walk_one(ea, 32'h040);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule